// File: doc/BRIEF.md
# Accumulator-to-Intermediate Clamp Stage

This stage sits after a three-lane multiply-accumulate unit. It takes three signed 32-bit accumulator results and turns each one into a 16-bit intermediate value by clamping it to a fixed window. A limit-mode input picks the window. With the mode clear the window is the full signed 16-bit range. With the mode set the window is non-negative only, so any negative result becomes zero.

Each lane that had to clamp records the event in a 32-bit status word. The stage receives that word from earlier pipeline stages and passes it on. Each lane owns one bit in the word. The first two lanes also set a shared summary bit, and the third lane never touches it. Bits that arrive already set stay set. The three clamped values leave sign-extended to 32 bits, so a later operation can feed them back in as a vector operand. The stage has one register level and a valid strobe that runs alongside the data.

Top module: `acc_ir_clamp`

## Requirements
- R1: With `lim_mode`=0, each lane output equals its accumulator clamped to the range -0x8000 to 0x7FFF.
- R2: With `lim_mode`=1, each lane output equals its accumulator clamped to the range 0 to 0x7FFF, so every negative input gives 0.
- R3: An accumulator inside the active window, including one exactly on either limit, passes through unchanged and sets no bit in the status word.
- R4: A clamp on lane 1, at either limit, sets status bit 24 and summary bit 31.
- R5: A clamp on lane 2, at either limit, sets status bit 23 and summary bit 31.
- R6: A clamp on lane 3, at either limit, sets status bit 22 only. Bit 31 is not set by lane 3.
- R7: Every bit set in `in_flags` is also set in `out_flags`. Bits that no lane sets pass through unchanged.
- R8: Bits 31:16 of each `irN` output equal bit 15 of that output (sign extension).
- R9: Outputs update on the first rising clock edge at which `in_valid` is 1. `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is 0, the data outputs hold their values.
- R10: While `rst` is high at a clock edge, `out_valid`, all `irN` outputs and `out_flags` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input operands are valid this cycle |
| lim_mode | input | 1 | 0: signed window; 1: non-negative window |
| acc1 | input | 32 | Lane 1 accumulator, signed |
| acc2 | input | 32 | Lane 2 accumulator, signed |
| acc3 | input | 32 | Lane 3 accumulator, signed |
| in_flags | input | 32 | Incoming status word |
| out_valid | output | 1 | The outputs are valid this cycle |
| ir1 | output | 32 | Lane 1 clamped value, sign-extended |
| ir2 | output | 32 | Lane 2 clamped value, sign-extended |
| ir3 | output | 32 | Lane 3 clamped value, sign-extended |
| out_flags | output | 32 | Status word with the clamp bits ORed in |

## Verification
The bench sweeps every combination of eleven edge values on all three lanes, in both modes. The values are the extreme 32-bit numbers, each window limit, and one step on each side of each limit. A comparison with an off-by-one error would change ±0x7FFF, -0x8000 or 0 and would set a flag on a value that sits exactly on a limit. Truncation instead of clamping would show up at ±0x8000 and at the 32-bit extremes. The incoming status word alternates between random contents and a pattern with the summary and lane bits cleared. This exposes a third lane that wrongly raises the summary bit, and any design that drops bits that were already set. One cycle with `in_valid` low checks that the outputs hold their values.

// File: rtl/acc_clamp_pkg.sv
package acc_clamp_pkg;

    localparam int ACC_W        = 32;
    localparam int IR_W         = 16;
    localparam int FLAG_W       = 32;
    localparam int NCH          = 3;
    // Lane n (0-based) reports on bit LANE_BIT_TOP - n.
    localparam int LANE_BIT_TOP = 24;
    localparam int SUM_BIT      = 31;
    // Lanes below this index also raise the summary bit.
    localparam int SUM_LANES    = 2;

    typedef struct packed {
        logic [IR_W-1:0] val;
        logic            hit;
    } lane_res_t;

    function automatic int lane_bit(input int lane);
        return LANE_BIT_TOP - lane;
    endfunction

    function automatic logic [ACC_W-1:0] sext_ir(input logic [IR_W-1:0] v);
        return {{(ACC_W-IR_W){v[IR_W-1]}}, v};
    endfunction

endpackage

// File: rtl/clamp_lane.sv
module clamp_lane
    import acc_clamp_pkg::*;
(
    input  logic signed [ACC_W-1:0] acc,
    input  logic                    lim_mode,
    output lane_res_t               res
);
    localparam logic signed [ACC_W-1:0] CEIL_V =
        {{(ACC_W-IR_W+1){1'b0}}, {(IR_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] FLOOR_V =
        {{(ACC_W-IR_W+1){1'b1}}, {(IR_W-1){1'b0}}};

    logic signed [ACC_W-1:0] floor_sel;

    always_comb begin
        floor_sel = lim_mode ? '0 : FLOOR_V;
        if (acc > CEIL_V) begin
            res.val = CEIL_V[IR_W-1:0];
            res.hit = 1'b1;
        end else if (acc < floor_sel) begin
            res.val = floor_sel[IR_W-1:0];
            res.hit = 1'b1;
        end else begin
            res.val = acc[IR_W-1:0];
            res.hit = 1'b0;
        end
    end

endmodule

// File: rtl/flag_merge.sv
module flag_merge
    import acc_clamp_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [NCH-1:0]    hit,
    output logic [FLAG_W-1:0] flags_out
);
    always_comb begin
        flags_out = flags_in;
        for (int ln = 0; ln < NCH; ln++) begin
            if (hit[ln]) begin
                flags_out[lane_bit(ln)] = 1'b1;
                if (ln < SUM_LANES) flags_out[SUM_BIT] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/acc_ir_clamp.sv
module acc_ir_clamp
    import acc_clamp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    lim_mode,
    input  logic signed [ACC_W-1:0] acc1,
    input  logic signed [ACC_W-1:0] acc2,
    input  logic signed [ACC_W-1:0] acc3,
    input  logic [FLAG_W-1:0]       in_flags,
    output logic                    out_valid,
    output logic [ACC_W-1:0]        ir1,
    output logic [ACC_W-1:0]        ir2,
    output logic [ACC_W-1:0]        ir3,
    output logic [FLAG_W-1:0]       out_flags
);
    logic signed [ACC_W-1:0] acc_a [NCH];
    lane_res_t               res_a [NCH];
    logic [NCH-1:0]          hit_v;
    logic [FLAG_W-1:0]       merged;
    logic [IR_W-1:0]         ir_q  [NCH];

    assign acc_a[0] = acc1;
    assign acc_a[1] = acc2;
    assign acc_a[2] = acc3;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        clamp_lane u_lane (
            .acc      (acc_a[g]),
            .lim_mode (lim_mode),
            .res      (res_a[g])
        );
        assign hit_v[g] = res_a[g].hit;
    end

    flag_merge u_merge (
        .flags_in  (in_flags),
        .hit       (hit_v),
        .flags_out (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_flags <= '0;
            for (int i = 0; i < NCH; i++) ir_q[i] <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_flags <= merged;
                for (int i = 0; i < NCH; i++) ir_q[i] <= res_a[i].val;
            end
        end
    end

    assign ir1 = sext_ir(ir_q[0]);
    assign ir2 = sext_ir(ir_q[1]);
    assign ir3 = sext_ir(ir_q[2]);

    assert_nonneg_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(lim_mode) |-> !ir1[ACC_W-1] && !ir2[ACC_W-1] && !ir3[ACC_W-1]);

    assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid && !$past(lim_mode) && ($past(acc1) >= -32'sd32768) && ($past(acc1) <= 32'sd32767)
        |-> (ir1 == $past(acc1)) && (out_flags[lane_bit(0)] == $past(in_flags[lane_bit(0)])));

    assert_lane3_no_summary_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !$past(in_flags[SUM_BIT]) && !out_flags[lane_bit(0)] && !out_flags[lane_bit(1)]
        |-> !out_flags[SUM_BIT]);

    assert_keep_flags_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_flags & $past(in_flags)) == $past(in_flags)));

    assert_valid_delay_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(ir1) && $stable(ir2) && $stable(ir3) && $stable(out_flags));

endmodule

// File: tb/acc_ir_clamp_tb_top.sv
module acc_ir_clamp_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        lim_mode;
    logic signed [31:0] acc1, acc2, acc3;
    logic [31:0] in_flags;
    logic        out_valid;
    logic [31:0] ir1, ir2, ir3, out_flags;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_ir_clamp dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lim_mode(lim_mode),
        .acc1(acc1), .acc2(acc2), .acc3(acc3), .in_flags(in_flags),
        .out_valid(out_valid), .ir1(ir1), .ir2(ir2), .ir3(ir3), .out_flags(out_flags)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic signed [31:0] edge_val(input int i);
        case (i)
            0:  return 32'sh8000_0000;
            1:  return -32'sd32769;
            2:  return -32'sd32768;
            3:  return -32'sd32767;
            4:  return -32'sd1;
            5:  return 32'sd0;
            6:  return 32'sd1;
            7:  return 32'sd32766;
            8:  return 32'sd32767;
            9:  return 32'sd32768;
            default: return 32'sh7FFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] exp_ir(input logic signed [31:0] v, input logic lm, output logic hit);
        longint lo, x;
        lo = lm ? 0 : -32768;
        x  = v;
        hit = 1'b1;
        if (x > 32767) return 32'd32767;
        if (x < lo)    return 32'(lo);
        hit = 1'b0;
        return v;
    endfunction

    task automatic check_lane(input int ln, input logic [31:0] act, input logic signed [31:0] v,
                              input logic lm, output logic hit);
        logic [31:0] e;
        string tag;
        e = exp_ir(v, lm, hit);
        tag = hit ? (lm ? "R2 clamp" : "R1 clamp") : "R3 passthrough";
        check($sformatf("%s lane%0d", tag, ln), act, e);
        check($sformatf("R8 sign extension lane%0d", ln), {16'h0, act[31:16]},
              {16'h0, {16{act[15]}}});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lcg;
        logic [31:0] fin, ef;
        logic h1, h2, h3;
        logic [31:0] keep1, keepf;
        lcg = 32'h1234_5678;
        rst = 1'b1; in_valid = 1'b0; lim_mode = 1'b0;
        acc1 = 32'sh7FFF_FFFF; acc2 = 32'sh8000_0000; acc3 = 32'sd5; in_flags = '1;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 out_valid after reset", {31'h0, out_valid}, 32'h0);
        check("R10 ir1 after reset", ir1, 32'h0);
        check("R10 ir2 after reset", ir2, 32'h0);
        check("R10 ir3 after reset", ir3, 32'h0);
        check("R10 out_flags after reset", out_flags, 32'h0);
        rst = 1'b0;

        for (int lm = 0; lm < 2; lm++) begin
            for (int a = 0; a < 11; a++) begin
                for (int b = 0; b < 11; b++) begin
                    for (int c = 0; c < 11; c++) begin
                        lcg = lcg * 32'd1664525 + 32'd1013904223;
                        fin = lcg;
                        if (((a + b + c) % 2) == 1) fin = fin & ~32'h81C0_0000;
                        lim_mode = lm[0];
                        acc1 = edge_val(a); acc2 = edge_val(b); acc3 = edge_val(c);
                        in_flags = fin; in_valid = 1'b1;
                        @(posedge clk);
                        #1;
                        check("R9 out_valid follows in_valid", {31'h0, out_valid}, 32'h1);
                        check_lane(1, ir1, edge_val(a), lm[0], h1);
                        check_lane(2, ir2, edge_val(b), lm[0], h2);
                        check_lane(3, ir3, edge_val(c), lm[0], h3);
                        ef = fin;
                        if (h1) ef = ef | 32'h8100_0000;
                        if (h2) ef = ef | 32'h8080_0000;
                        if (h3) ef = ef | 32'h0040_0000;
                        check("R4 lane1 flag bit 24", {31'h0, out_flags[24]}, {31'h0, ef[24]});
                        check("R5 lane2 flag bit 23", {31'h0, out_flags[23]}, {31'h0, ef[23]});
                        check("R6 lane3 flag bit 22", {31'h0, out_flags[22]}, {31'h0, ef[22]});
                        check("R4 R5 R6 summary bit 31", {31'h0, out_flags[31]}, {31'h0, ef[31]});
                        check("R7 other flag bits kept", out_flags & 32'h7E3F_FFFF, ef & 32'h7E3F_FFFF);
                    end
                end
            end
        end

        // R9 hold while in_valid low
        keep1 = ir1; keepf = out_flags;
        in_valid = 1'b0; acc1 = 32'sd77; in_flags = 32'h0;
        @(posedge clk);
        #1;
        check("R9 out_valid low when idle", {31'h0, out_valid}, 32'h0);
        check("R9 ir1 holds when idle", ir1, keep1);
        check("R9 out_flags holds when idle", out_flags, keepf);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule